// File: doc/BRIEF.md
# Flow-Through Burst SRAM Access Controller

This block holds the control and data-path logic of a common-I/O synchronous SRAM whose read data flows through without an output register. A small behavioural array holds words of four byte lanes. Each lane has eight data bits and one parity bit. An access starts on one of two address strobes. One strobe comes from a processor. The other comes from a cache controller. Either strobe loads a two-bit wrapping burst counter, which then steps on an advance input in linear or interleaved order.

The global-write, byte-write and per-lane select inputs are decoded into lane write strobes. The edge on which a write can first land depends on the strobe that opened the access. The data bus is split into an input, an output and a driver enable. The pad ring combines them into one tri-state bus. The enable is gated at once by the output-enable input and by any write request. A sleep input is synchronised, and it parks the controller for a fixed number of edges on entry and on exit.

This is a pin-level memory interface with plain control pins. It has no stream handshake. Every access completes in the cycle it is sampled, and the block never applies back-pressure.

Top module: `fsram_ctrl`

## Requirements
- R1: When wr_all_n is low at an edge that performs a write, all four lanes are written, whatever the values of wr_byte_n and byte_sel_n.
- R2: When wr_all_n is high, lane b is written only if wr_byte_n is low and byte_sel_n[b] is low. Lane b is dq bits [8b+7:8b] together with dq bit 32+b. When wr_byte_n is high, nothing is written.
- R3: At an edge where the processor strobe opens an access (cpu_start_n low with sel_a_n low), the write inputs have no effect. A write requested at the following edge, with no strobe and adv_n high, lands at the address loaded by the strobe.
- R4: At an edge where the controller strobe opens an access (ctl_start_n low, processor strobe not effective), a write requested by the write inputs lands at that same edge, at addr.
- R5: After an edge that opens an access with the write inputs inactive, dq_o shows the word at that address during the next cycle, with no further register. dq_en is high while oe_n is low.
- R6: dq_en is low at once whenever oe_n is high, or whenever a write is requested (wr_all_n low, or wr_byte_n low with any byte_sel_n bit low).
- R7: A strobe is accepted only when sel_a_n is low, sel_b is high and sel_c_n is low. Otherwise the edge deselects the block: nothing is written and dq_en goes low.
- R8: At an edge inside a burst with no strobe and adv_n low, the counter steps by one. The access uses the new address. The upper address bits stay fixed. The low two bits are start+k mod 4 when ilv_mode is 0, and start XOR k when ilv_mode is 1, for k = 1..3 and then wrapping.
- R9: When sleep_req is raised before edge 1, accesses on edges 1 and 2 still take effect. From edge 3 on, strobes and writes are ignored, the array contents are kept and dq_en stays low.
- R10: When sleep_req is released before edge 1, strobes on edges 1 through 5 are ignored. A strobe on edge 6 is accepted.
- R11: A burst open at sleep entry is discarded. After wake, write inputs with no strobe do not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| ilv_mode | input | 1 | Burst order: 1 selects interleaved, 0 selects linear |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| cpu_start_n | input | 1 | Processor address strobe, active low; wins over the controller strobe |
| ctl_start_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | 4 | Per-lane write select, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| addr | input | 6 | Word address; bits [1:0] seed the burst counter |
| dq_i | input | 36 | Bus value seen at the pad |
| dq_o | output | 36 | Read data toward the pad |
| dq_en | output | 1 | Pad driver enable |

## Verification
The hardest case to reach is the edge just after sleep release. The synchroniser, the exit state and the two recovery edges must all block accesses, and the block must accept again on exactly the sixth edge. The bench releases sleep while holding a controller write on every edge from the first to the fifth. It then writes a different address on the sixth edge and reads both back. A burst left open across a sleep is reached the same way: a processor-strobe read comes first, then a full sleep cycle, then a strobe-less write.

// File: rtl/fsram_pkg.sv
package fsram_pkg;
  typedef enum logic [1:0] {SL_RUN, SL_ENTER, SL_DOZE, SL_WAKE} slp_e;

  // low two address bits for burst step k from start value s
  function automatic logic [1:0] burst_lo(input logic [1:0] s, input logic [1:0] k,
                                          input logic ilv);
    return ilv ? (s ^ k) : (s + k);
  endfunction
endpackage

// File: rtl/fsram_wdec.sv
module fsram_wdec #(
  parameter int LANES = 4
) (
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] byte_sel_n,
  output logic [LANES-1:0] lane_req
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_req[b] = !wr_all_n || (!wr_byte_n && !byte_sel_n[b]);
  end
endmodule

// File: rtl/fsram_burst.sv
module fsram_burst
  import fsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr
);
  logic [ADDR_W-3:0] hi_q;
  logic [1:0]        start_q;
  logic [1:0]        k_q;
  logic [1:0]        k_nx;

  assign k_nx     = step ? k_q + 2'd1 : k_q;
  assign acc_addr = load ? addr_in : {hi_q, burst_lo(start_q, k_nx, ilv)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      k_q     <= '0;
    end else if (load) begin
      hi_q    <= addr_in[ADDR_W-1:2];
      start_q <= addr_in[1:0];
      k_q     <= '0;
    end else begin
      k_q     <= k_nx;
    end
  end
endmodule

// File: rtl/fsram_sleep.sv
module fsram_sleep
  import fsram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  output logic awake
);
  logic s1_q, s2_q, wcnt_q;
  slp_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= sleep_req;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SL_RUN;
      wcnt_q <= 1'b0;
    end else begin
      case (st_q)
        SL_RUN:   if (s2_q) st_q <= SL_ENTER;
        SL_ENTER: st_q <= SL_DOZE;
        SL_DOZE:  if (!s2_q) begin
                    st_q   <= SL_WAKE;
                    wcnt_q <= 1'b0;
                  end
        SL_WAKE:  if (wcnt_q) st_q <= SL_RUN;
                  else        wcnt_q <= 1'b1;
        default:  st_q <= SL_RUN;
      endcase
    end
  end

  assign awake = (st_q == SL_RUN) && !s2_q;
endmodule

// File: rtl/fsram_ctrl.sv
module fsram_ctrl
  import fsram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_DW = 8,
  localparam int WORD_W = LANES * (LANE_DW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              ilv_mode,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              cpu_start_n,
  input  logic              ctl_start_n,
  input  logic              adv_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  byte_sel_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dq_i,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAR_LO = LANES * LANE_DW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [LANES-1:0]  lane_req, lane_we;
  logic [ADDR_W-1:0] acc_addr, rd_addr_q;
  logic awake, cpu_eff, start, sel_ok, go, stop, cont, wr_ok, any_req;
  logic burst_q, rd_valid_q;

  fsram_sleep u_sleep (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .awake(awake)
  );

  fsram_wdec #(.LANES(LANES)) u_wdec (
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .byte_sel_n(byte_sel_n), .lane_req(lane_req)
  );

  assign cpu_eff = !cpu_start_n && !sel_a_n;
  assign start   = cpu_eff || !ctl_start_n;
  assign sel_ok  = !sel_a_n && sel_b && !sel_c_n;
  assign go      = awake && start && sel_ok;
  assign stop    = awake && start && !sel_ok;
  assign cont    = awake && !start && burst_q;
  assign wr_ok   = (go && !cpu_eff) || cont;
  assign lane_we = wr_ok ? lane_req : '0;
  assign any_req = |lane_req;

  fsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(go), .step(cont && !adv_n),
    .ilv(ilv_mode), .addr_in(addr), .acc_addr(acc_addr)
  );

  always_ff @(posedge clk) begin
    for (int b = 0; b < LANES; b++) begin
      if (lane_we[b]) begin
        mem[acc_addr][b*LANE_DW +: LANE_DW] <= dq_i[b*LANE_DW +: LANE_DW];
        mem[acc_addr][PAR_LO + b]           <= dq_i[PAR_LO + b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q    <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_addr_q  <= '0;
    end else if (!awake) begin
      burst_q    <= 1'b0;
      rd_valid_q <= 1'b0;
    end else if (go) begin
      burst_q    <= 1'b1;
      rd_valid_q <= cpu_eff || !any_req;
      rd_addr_q  <= acc_addr;
    end else if (stop) begin
      burst_q    <= 1'b0;
      rd_valid_q <= 1'b0;
    end else if (cont) begin
      rd_valid_q <= !any_req;
      rd_addr_q  <= acc_addr;
    end
  end

  assign dq_o  = mem[rd_addr_q];
  assign dq_en = !oe_n && rd_valid_q && awake && !any_req;
endmodule

// File: rtl/fsram_ctrl_chk.sv
module fsram_ctrl_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n,
  input logic             wr_all_n,
  input logic             wr_byte_n,
  input logic [LANES-1:0] byte_sel_n,
  input logic             cpu_start_n,
  input logic             sel_a_n,
  input logic             dq_en,
  input logic             awake,
  input logic [LANES-1:0] lane_we
);
  a_r6_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_en);
  a_r6_write_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_all_n || (!wr_byte_n && byte_sel_n != '1)) |-> !dq_en);
  a_r3_cpu_first_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_start_n && !sel_a_n) |-> lane_we == '0);
  a_r1_global_all: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0 && !wr_all_n) |-> lane_we == '1);
  a_r2_lane_select: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0 && wr_all_n) |-> (!wr_byte_n && (lane_we & byte_sel_n) == '0));
  a_r9_doze_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> lane_we == '0);
  a_r9_doze_bus_off: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> !dq_en);
endmodule

bind fsram_ctrl fsram_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .wr_all_n(wr_all_n),
  .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n), .cpu_start_n(cpu_start_n),
  .sel_a_n(sel_a_n), .dq_en(dq_en), .awake(awake), .lane_we(lane_we)
);

// File: tb/sim_fsram_ctrl.sv
module sim_fsram_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req, ilv_mode, sel_a_n, sel_b, sel_c_n, cpu_start_n, ctl_start_n, adv_n;
  logic wr_all_n, wr_byte_n, oe_n;
  logic [3:0]  byte_sel_n;
  logic [5:0]  addr;
  logic [35:0] dq_i, dq_o;
  logic        dq_en;
  logic [35:0] sh [64];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fsram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ilv_mode(ilv_mode),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .cpu_start_n(cpu_start_n),
    .ctl_start_n(ctl_start_n), .adv_n(adv_n), .wr_all_n(wr_all_n),
    .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n), .oe_n(oe_n), .addr(addr),
    .dq_i(dq_i), .dq_o(dq_o), .dq_en(dq_en)
  );

  function automatic logic [35:0] pat(input int a, input int salt);
    logic [31:0] d;
    d = 32'(a) * 32'h0101_0101 ^ 32'(salt) * 32'h9E37_79B9;
    return {4'(a ^ salt), d};
  endfunction

  function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                        input logic [3:0] on);
    logic [35:0] r;
    r = old;
    for (int b = 0; b < 4; b++) begin
      if (on[b]) begin
        r[b*8 +: 8] = nw[b*8 +: 8];
        r[32 + b]   = nw[32 + b];
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    cpu_start_n = 1'b1; ctl_start_n = 1'b1; adv_n = 1'b1;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; byte_sel_n = 4'hF; oe_n = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic idle_cycle();
    @(negedge clk); idle_in(); tick();
  endtask

  task automatic ctl_wr(input int a, input logic [35:0] d, input logic all_n,
                        input logic bw_n, input logic [3:0] sel_n);
    @(negedge clk); idle_in();
    ctl_start_n = 1'b0; addr = 6'(a); dq_i = d;
    wr_all_n = all_n; wr_byte_n = bw_n; byte_sel_n = sel_n;
    tick();
  endtask

  task automatic ctl_rd(input int a);
    @(negedge clk); idle_in();
    ctl_start_n = 1'b0; addr = 6'(a);
    tick();
  endtask

  task automatic rd_chk(input string req, input int a);
    ctl_rd(a);
    chk(req, dq_o, sh[a]);
    chk(req, {35'd0, dq_en}, 36'd1);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [35:0] d;
    idle_in(); sleep_req = 1'b0; ilv_mode = 1'b0; addr = '0; dq_i = '0;
    repeat (3) @(posedge clk);
    #5;
    chk("R6 reset bus off", {35'd0, dq_en}, 36'd0);
    @(negedge clk); rst_n = 1'b1;

    // R4 R1: controller-strobe global writes fill the array, then R5 reads
    for (int a = 0; a < 64; a++) begin
      ctl_wr(a, pat(a, 1), 1'b0, 1'b1, 4'hF);
      sh[a] = pat(a, 1);
      chk("R6 bus off during write", {35'd0, dq_en}, 36'd0);
    end
    for (int a = 0; a < 64; a++) rd_chk("R4 R5 fill readback", a);

    // R5 R6: asynchronous output enable after a read
    ctl_rd(3);
    #2 oe_n = 1'b1;
    #1 chk("R6 oe high bus off", {35'd0, dq_en}, 36'd0);
    oe_n = 1'b0;
    #1 chk("R5 oe low bus on", {35'd0, dq_en}, 36'd1);
    chk("R5 flow-through data", dq_o, sh[3]);

    // R2: every lane mask; R2 byte enable off; R1 global priority
    for (int m = 0; m < 16; m++) begin
      ctl_wr(m, pat(m, 7), 1'b1, 1'b0, 4'(m));
      sh[m] = merge(sh[m], pat(m, 7), ~4'(m));
      ctl_wr(16 + m, pat(m, 9), 1'b1, 1'b1, 4'(m));
      ctl_wr(32 + m, pat(m, 11), 1'b0, 1'b1, 4'(m));
      sh[32 + m] = pat(m, 11);
    end
    for (int m = 0; m < 16; m++) begin
      rd_chk("R2 lane mask", m);
      rd_chk("R2 byte enable off", 16 + m);
      rd_chk("R1 global overrides lanes", 32 + m);
    end

    // R3: processor strobe ignores first-cycle write, writes next edge
    @(negedge clk); idle_in();
    cpu_start_n = 1'b0; addr = 6'd5; wr_all_n = 1'b0; dq_i = pat(5, 21);
    tick();
    chk("R6 bus off on write request", {35'd0, dq_en}, 36'd0);
    @(negedge clk); idle_in();
    wr_byte_n = 1'b0; byte_sel_n = 4'b1110; dq_i = pat(5, 22);
    tick();
    sh[5] = merge(sh[5], pat(5, 22), 4'b0001);
    rd_chk("R3 write lands on second edge only", 5);

    // R7: deselected strobes do nothing
    @(negedge clk); idle_in();
    sel_b = 1'b0; ctl_start_n = 1'b0; addr = 6'd10; wr_all_n = 1'b0; dq_i = pat(10, 30);
    tick();
    @(negedge clk); idle_in();
    sel_c_n = 1'b1; ctl_start_n = 1'b0; addr = 6'd11; wr_all_n = 1'b0; dq_i = pat(11, 30);
    tick();
    @(negedge clk); idle_in();
    sel_b = 1'b0; ctl_start_n = 1'b0; addr = 6'd12;
    tick();
    chk("R7 deselect bus off", {35'd0, dq_en}, 36'd0);
    rd_chk("R7 deselect no write", 10);
    rd_chk("R7 deselect no write", 11);

    // R8: both burst orders from every start offset
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); idle_in();
        ilv_mode = 1'(md); cpu_start_n = 1'b0; addr = 6'(48 + s);
        tick();
        chk("R8 burst first word", dq_o, sh[48 + s]);
        for (int k = 1; k < 4; k++) begin
          int lo;
          @(negedge clk); idle_in();
          adv_n = 1'b0;
          tick();
          lo = (md == 1) ? (s ^ k) : ((s + k) % 4);
          chk("R8 burst step", dq_o, sh[48 + lo]);
        end
      end
    end

    // R9: sleep entry timing
    @(negedge clk); idle_in(); sleep_req = 1'b1; addr = 6'd20; cpu_start_n = 1'b0;
    tick();
    ctl_wr(19, pat(19, 40), 1'b0, 1'b1, 4'hF);
    sh[19] = pat(19, 40);
    ctl_wr(21, pat(21, 41), 1'b0, 1'b1, 4'hF);
    ctl_rd(21);
    chk("R9 asleep bus off", {35'd0, dq_en}, 36'd0);
    repeat (4) idle_cycle();

    // R10: release; edges 1..5 ignored, edge 6 accepted
    @(negedge clk); sleep_req = 1'b0;
    for (int e = 1; e <= 5; e++) begin
      if (e > 1) @(negedge clk);
      idle_in(); ctl_start_n = 1'b0; addr = 6'd22; wr_all_n = 1'b0; dq_i = pat(22, 42);
      tick();
    end
    ctl_wr(23, pat(23, 43), 1'b0, 1'b1, 4'hF);
    sh[23] = pat(23, 43);
    rd_chk("R9 write before entry kept", 19);
    rd_chk("R9 asleep write ignored", 21);
    rd_chk("R10 recovery write ignored", 22);
    rd_chk("R10 sixth edge accepted", 23);

    // R11: burst open at sleep entry is discarded
    @(negedge clk); idle_in(); cpu_start_n = 1'b0; addr = 6'd24;
    tick();
    @(negedge clk); idle_in(); sleep_req = 1'b1;
    tick();
    repeat (6) idle_cycle();
    @(negedge clk); sleep_req = 1'b0;
    tick();
    repeat (7) idle_cycle();
    @(negedge clk); idle_in(); wr_all_n = 1'b0; dq_i = pat(24, 50);
    tick();
    d = sh[24];
    rd_chk("R11 pending burst discarded", 24);
    chk("R11 word unchanged", dq_o, d);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule